// File: doc/BRIEF.md
# Three-Initiator Priority Merge for a Shared Memory Port

This block lets three OCP initiators share one OCP target that sits in front of a single-port sample memory. A trigger path stores captured samples and can only write. A waveform path fetches playback samples and can only read. A host path can do both. The request path has no registers. In each cycle the block picks one requesting initiator by a fixed ranking and passes that initiator's command, address and 96-bit write data to the target. The target's accept goes back only to the initiator that won.

The target answers a read one cycle after it accepts it. The merge keeps a one-cycle tag that names which initiator issued the accepted read, and uses it to steer the answer back to that initiator. The other initiators see a NULL response in that cycle. A command whose direction the issuing port does not support is never sent to the target. The merge accepts it at once and returns an ERR response on that port in the next cycle.

Top module: `ocp_merge3`

## Requirements
- R1: After reset, and while no command is present, every SCmdAccept output is 0, every SResp output is NULL (2'b00) and the target MCmd is IDLE.
- R2: MCmd uses 3 bits: IDLE=3'b000, WR=3'b001, RD=3'b010. A port is requesting when it presents a command its direction allows. When no port is requesting, the target sees MCmd=IDLE.
- R3: Ranking is fixed: trigger port first, host port second, waveform port last. In the same cycle the target sees the MCmd, address and write data of the highest-ranked requesting port.
- R4: SCmdAccept is raised only on the winning port, and only while the target accepts. Losing ports see 0 and must keep their request stable.
- R5: When a read is accepted, the target answer in the next cycle (SResp DVA=2'b01 plus SData) appears only on the port that issued the read. Every other port sees NULL and zero data.
- R6: A read on the trigger port, a write on the waveform port, and any MCmd code other than IDLE, WR or RD are illegal. An illegal command is not forwarded. It is accepted in the same cycle, and SResp=ERR (2'b11) appears on that port in the next cycle. Other ports are still served in that cycle.
- R7: The host port's reads and writes are both forwarded.
- R8: While the target holds its accept low, no port sees an accept for a forwarded command, and no read answer is routed in the following cycle.
- R9: While the trigger port writes in every cycle, the lower ports receive no accept. A pending lower request is served in the first cycle the trigger port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trg_mcmd | input | 3 | Trigger port command |
| trg_maddr | input | ADDR_W | Trigger port address |
| trg_mdata | input | DATA_W | Trigger port write data |
| trg_scmdaccept | output | 1 | Trigger port accept |
| trg_sresp | output | 2 | Trigger port response |
| trg_sdata | output | DATA_W | Trigger port read data (always zero, port cannot read) |
| hst_mcmd | input | 3 | Host port command |
| hst_maddr | input | ADDR_W | Host port address |
| hst_mdata | input | DATA_W | Host port write data |
| hst_scmdaccept | output | 1 | Host port accept |
| hst_sresp | output | 2 | Host port response |
| hst_sdata | output | DATA_W | Host port read data |
| wav_mcmd | input | 3 | Waveform port command |
| wav_maddr | input | ADDR_W | Waveform port address |
| wav_scmdaccept | output | 1 | Waveform port accept |
| wav_sresp | output | 2 | Waveform port response |
| wav_sdata | output | DATA_W | Waveform port read data |
| tgt_mcmd | output | 3 | Command to target |
| tgt_maddr | output | ADDR_W | Address to target |
| tgt_mdata | output | DATA_W | Write data to target |
| tgt_scmdaccept | input | 1 | Target accept |
| tgt_sresp | input | 2 | Target response |
| tgt_sdata | input | DATA_W | Target read data |

## Verification
The only state in the block is the read tag and the per-port error flags. A wrong tag shows up exactly one cycle after an accepted read: the DVA response and the data land on the wrong port, or on no port at all. A lost or misplaced error flag shows the same cycle later as a missing or stray ERR. Mistakes in the ranking or the accept gating have no state to hide behind. They appear at the ports in the same cycle as the request.

// File: rtl/ocpm_pkg.sv
// Shared constants for the three-initiator merge: command and response
// codes, port indices and the fixed direction capability of each port.
package ocpm_pkg;
    localparam int NPORT = 3;

    // Port index doubles as rank: lower index wins.
    localparam int IDX_TRG = 0;
    localparam int IDX_HST = 1;
    localparam int IDX_WAV = 2;

    localparam logic [2:0] CMD_IDLE = 3'b000;
    localparam logic [2:0] CMD_WR   = 3'b001;
    localparam logic [2:0] CMD_RD   = 3'b010;

    localparam logic [1:0] RSP_NULL = 2'b00;
    localparam logic [1:0] RSP_DVA  = 2'b01;
    localparam logic [1:0] RSP_ERR  = 2'b11;

    // Bit i set: port i may issue that direction.
    localparam logic [NPORT-1:0] CAN_WR = 3'b011;
    localparam logic [NPORT-1:0] CAN_RD = 3'b110;
endpackage

// File: rtl/ocpm_classify.sv
// Sorts each port's command into a legal request or an illegal one.
// Assumes: a port's command is steady while it waits for its accept.
module ocpm_classify #(
    parameter int                N      = 3,
    parameter logic [N-1:0]      WR_OK  = '1,
    parameter logic [N-1:0]      RD_OK  = '1
) (
    input  logic [N-1:0][2:0] cmd,
    output logic [N-1:0]      req,
    output logic [N-1:0]      bad
);
    import ocpm_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_port
        logic is_wr, is_rd, is_idle;
        assign is_wr   = (cmd[i] == CMD_WR);
        assign is_rd   = (cmd[i] == CMD_RD);
        assign is_idle = (cmd[i] == CMD_IDLE);
        // Legal when the direction matches the port's capability.
        assign req[i] = (is_wr & WR_OK[i]) | (is_rd & RD_OK[i]);
        // Anything else that is not idle is an error.
        assign bad[i] = ~is_idle & ~req[i];
    end
endmodule

// File: rtl/ocpm_prio_arb.sv
// Fixed-priority arbiter; index 0 ranks highest. Purely combinational.
// Assumes: req comes from ocpm_classify and holds only legal requests.
module ocpm_prio_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N-1:0] above;

    assign above[0] = 1'b0;
    for (genvar i = 1; i < N; i++) begin : g_chain
        // Any higher-ranked request blocks this port.
        assign above[i] = above[i-1] | req[i-1];
    end

    for (genvar i = 0; i < N; i++) begin : g_gnt
        assign gnt[i] = req[i] & ~above[i];
    end
endmodule

// File: rtl/ocpm_req_mux.sv
// One-hot AND-OR selector that presents the winning port's request
// fields to the target and reports the winner's index.
// Assumes: gnt is one-hot or zero; zero gives an IDLE command.
module ocpm_req_mux #(
    parameter int N  = 3,
    parameter int AW = 12,
    parameter int DW = 96,
    parameter int IW = 2
) (
    input  logic [N-1:0]         gnt,
    input  logic [N-1:0][2:0]    cmd,
    input  logic [N-1:0][AW-1:0] addr,
    input  logic [N-1:0][DW-1:0] data,
    output logic [2:0]           o_cmd,
    output logic [AW-1:0]        o_addr,
    output logic [DW-1:0]        o_data,
    output logic [IW-1:0]        o_idx
);
    // Merge the granted port's fields onto the target bus.
    always_comb begin
        o_cmd  = '0;
        o_addr = '0;
        o_data = '0;
        o_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                o_cmd  = o_cmd  | cmd[i];
                o_addr = o_addr | addr[i];
                o_data = o_data | data[i];
                o_idx  = o_idx  | IW'(i);
            end
        end
    end
endmodule

// File: rtl/ocpm_rsp_route.sv
// Return path: remembers the port of the read accepted in the previous
// cycle, steers the target answer to it, and raises ERR on ports whose
// illegal command was absorbed in the previous cycle.
// Assumes: the target answers a read exactly one cycle after accepting it.
module ocpm_rsp_route #(
    parameter int N  = 3,
    parameter int DW = 96,
    parameter int IW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_taken,
    input  logic [IW-1:0]        rd_idx,
    input  logic [N-1:0]         bad,
    input  logic [1:0]           t_resp,
    input  logic [DW-1:0]        t_data,
    output logic [N-1:0][1:0]    p_resp,
    output logic [N-1:0][DW-1:0] p_data
);
    import ocpm_pkg::*;

    logic          tag_vld;
    logic [IW-1:0] tag_idx;
    logic [N-1:0]  err_q;

    // Capture the issuer of an accepted read and any illegal commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vld <= 1'b0;
            tag_idx <= '0;
            err_q   <= '0;
        end else begin
            tag_vld <= rd_taken;
            tag_idx <= rd_idx;
            err_q   <= bad;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        logic hit;
        assign hit = tag_vld && (tag_idx == IW'(i)) && (t_resp != RSP_NULL);
        assign p_resp[i] = err_q[i] ? RSP_ERR : (hit ? t_resp : RSP_NULL);
        assign p_data[i] = hit ? t_data : '0;
    end
endmodule

// File: rtl/ocp_merge3.sv
// Three-to-one fixed-priority OCP merge in front of a single-port memory.
// Ranking: trigger, host, waveform. The request path is combinational.
// Read answers return through a one-cycle tag.
// Assumes: single-beat transfers, one-cycle read latency at the target,
// and losing initiators hold their request until accepted.
module ocp_merge3 #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        trg_mcmd,
    input  logic [ADDR_W-1:0] trg_maddr,
    input  logic [DATA_W-1:0] trg_mdata,
    output logic              trg_scmdaccept,
    output logic [1:0]        trg_sresp,
    output logic [DATA_W-1:0] trg_sdata,
    input  logic [2:0]        hst_mcmd,
    input  logic [ADDR_W-1:0] hst_maddr,
    input  logic [DATA_W-1:0] hst_mdata,
    output logic              hst_scmdaccept,
    output logic [1:0]        hst_sresp,
    output logic [DATA_W-1:0] hst_sdata,
    input  logic [2:0]        wav_mcmd,
    input  logic [ADDR_W-1:0] wav_maddr,
    output logic              wav_scmdaccept,
    output logic [1:0]        wav_sresp,
    output logic [DATA_W-1:0] wav_sdata,
    output logic [2:0]        tgt_mcmd,
    output logic [ADDR_W-1:0] tgt_maddr,
    output logic [DATA_W-1:0] tgt_mdata,
    input  logic              tgt_scmdaccept,
    input  logic [1:0]        tgt_sresp,
    input  logic [DATA_W-1:0] tgt_sdata
);
    import ocpm_pkg::*;

    localparam int IW = $clog2(NPORT);

    logic [NPORT-1:0][2:0]        cmd_a;
    logic [NPORT-1:0][ADDR_W-1:0] addr_a;
    logic [NPORT-1:0][DATA_W-1:0] data_a;
    logic [NPORT-1:0]             req, bad, gnt, acc;
    logic [NPORT-1:0][1:0]        resp_a;
    logic [NPORT-1:0][DATA_W-1:0] rdat_a;
    logic [IW-1:0]                win_idx;
    logic                         rd_taken;

    // Gather the named ports into indexed arrays.
    assign cmd_a[IDX_TRG]  = trg_mcmd;
    assign cmd_a[IDX_HST]  = hst_mcmd;
    assign cmd_a[IDX_WAV]  = wav_mcmd;
    assign addr_a[IDX_TRG] = trg_maddr;
    assign addr_a[IDX_HST] = hst_maddr;
    assign addr_a[IDX_WAV] = wav_maddr;
    assign data_a[IDX_TRG] = trg_mdata;
    assign data_a[IDX_HST] = hst_mdata;
    assign data_a[IDX_WAV] = '0;

    ocpm_classify #(.N(NPORT), .WR_OK(CAN_WR), .RD_OK(CAN_RD)) u_cls (
        .cmd (cmd_a),
        .req (req),
        .bad (bad)
    );

    ocpm_prio_arb #(.N(NPORT)) u_arb (
        .req (req),
        .gnt (gnt)
    );

    ocpm_req_mux #(.N(NPORT), .AW(ADDR_W), .DW(DATA_W), .IW(IW)) u_mux (
        .gnt    (gnt),
        .cmd    (cmd_a),
        .addr   (addr_a),
        .data   (data_a),
        .o_cmd  (tgt_mcmd),
        .o_addr (tgt_maddr),
        .o_data (tgt_mdata),
        .o_idx  (win_idx)
    );

    // Winner takes the target accept; illegal commands are absorbed at once.
    assign acc      = (gnt & {NPORT{tgt_scmdaccept}}) | bad;
    assign rd_taken = (tgt_mcmd == CMD_RD) && tgt_scmdaccept;

    ocpm_rsp_route #(.N(NPORT), .DW(DATA_W), .IW(IW)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_taken (rd_taken),
        .rd_idx   (win_idx),
        .bad      (bad),
        .t_resp   (tgt_sresp),
        .t_data   (tgt_sdata),
        .p_resp   (resp_a),
        .p_data   (rdat_a)
    );

    // Spread the indexed results back to the named ports.
    assign trg_scmdaccept = acc[IDX_TRG];
    assign hst_scmdaccept = acc[IDX_HST];
    assign wav_scmdaccept = acc[IDX_WAV];
    assign trg_sresp      = resp_a[IDX_TRG];
    assign hst_sresp      = resp_a[IDX_HST];
    assign wav_sresp      = resp_a[IDX_WAV];
    assign trg_sdata      = rdat_a[IDX_TRG];
    assign hst_sdata      = rdat_a[IDX_HST];
    assign wav_sdata      = rdat_a[IDX_WAV];
endmodule

// File: rtl/ocpm_chk.sv
// Port-level properties of ocp_merge3, attached by bind below.
module ocpm_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        trg_mcmd,
    input logic [ADDR_W-1:0] trg_maddr,
    input logic              trg_scmdaccept,
    input logic [1:0]        trg_sresp,
    input logic [2:0]        hst_mcmd,
    input logic              hst_scmdaccept,
    input logic [2:0]        wav_mcmd,
    input logic              wav_scmdaccept,
    input logic [1:0]        wav_sresp,
    input logic [DATA_W-1:0] wav_sdata,
    input logic [2:0]        tgt_mcmd,
    input logic [ADDR_W-1:0] tgt_maddr,
    input logic              tgt_scmdaccept,
    input logic [1:0]        tgt_sresp,
    input logic [DATA_W-1:0] tgt_sdata
);
    import ocpm_pkg::*;

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_mcmd == CMD_IDLE && hst_mcmd == CMD_IDLE && wav_mcmd == CMD_IDLE)
        |-> tgt_mcmd == CMD_IDLE);

    // R3
    trg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_mcmd == CMD_WR) |-> (tgt_mcmd == CMD_WR && tgt_maddr == trg_maddr));

    // R4
    loser_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_mcmd == CMD_WR) |-> (!hst_scmdaccept &&
                                  !(wav_scmdaccept && wav_mcmd == CMD_RD)));

    // R5
    wav_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wav_mcmd == CMD_RD && wav_scmdaccept)
        |=> (wav_sresp == tgt_sresp && wav_sdata == tgt_sdata));

    // R6
    trg_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_mcmd == CMD_RD) |=> (trg_sresp == RSP_ERR));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_scmdaccept && trg_mcmd == CMD_WR) |-> !trg_scmdaccept);
endmodule

bind ocp_merge3 ocpm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trg_mcmd       (trg_mcmd),
    .trg_maddr      (trg_maddr),
    .trg_scmdaccept (trg_scmdaccept),
    .trg_sresp      (trg_sresp),
    .hst_mcmd       (hst_mcmd),
    .hst_scmdaccept (hst_scmdaccept),
    .wav_mcmd       (wav_mcmd),
    .wav_scmdaccept (wav_scmdaccept),
    .wav_sresp      (wav_sresp),
    .wav_sdata      (wav_sdata),
    .tgt_mcmd       (tgt_mcmd),
    .tgt_maddr      (tgt_maddr),
    .tgt_scmdaccept (tgt_scmdaccept),
    .tgt_sresp      (tgt_sresp),
    .tgt_sdata      (tgt_sdata)
);

// File: tb/tb_ocp_merge3.sv
`timescale 1ns/1ps
module tb_ocp_merge3;
    localparam int AW = 12;
    localparam int DW = 96;
    localparam logic [2:0] IDL = 3'b000, WR = 3'b001, RD = 3'b010;
    localparam logic [1:0] NUL = 2'b00, DVA = 2'b01, ERR = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [2:0] trg_mcmd = IDL, hst_mcmd = IDL, wav_mcmd = IDL;
    logic [AW-1:0] trg_maddr = '0, hst_maddr = '0, wav_maddr = '0;
    logic [DW-1:0] trg_mdata = '0, hst_mdata = '0;
    logic trg_scmdaccept, hst_scmdaccept, wav_scmdaccept;
    logic [1:0] trg_sresp, hst_sresp, wav_sresp;
    logic [DW-1:0] trg_sdata, hst_sdata, wav_sdata;
    logic [2:0] tgt_mcmd;
    logic [AW-1:0] tgt_maddr;
    logic [DW-1:0] tgt_mdata;
    logic tgt_rdy = 1'b1;
    logic [1:0] tgt_sresp;
    logic [DW-1:0] tgt_sdata;

    int checks = 0;
    int errors = 0;

    ocp_merge3 #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .trg_mcmd(trg_mcmd), .trg_maddr(trg_maddr), .trg_mdata(trg_mdata),
        .trg_scmdaccept(trg_scmdaccept), .trg_sresp(trg_sresp), .trg_sdata(trg_sdata),
        .hst_mcmd(hst_mcmd), .hst_maddr(hst_maddr), .hst_mdata(hst_mdata),
        .hst_scmdaccept(hst_scmdaccept), .hst_sresp(hst_sresp), .hst_sdata(hst_sdata),
        .wav_mcmd(wav_mcmd), .wav_maddr(wav_maddr),
        .wav_scmdaccept(wav_scmdaccept), .wav_sresp(wav_sresp), .wav_sdata(wav_sdata),
        .tgt_mcmd(tgt_mcmd), .tgt_maddr(tgt_maddr), .tgt_mdata(tgt_mdata),
        .tgt_scmdaccept(tgt_rdy), .tgt_sresp(tgt_sresp), .tgt_sdata(tgt_sdata)
    );

    // Target model: 16-word memory, reads answered one cycle after accept.
    logic [DW-1:0] mem [16];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_sresp <= NUL;
            tgt_sdata <= '0;
        end else begin
            if (tgt_mcmd == WR && tgt_rdy) mem[tgt_maddr[3:0]] <= tgt_mdata;
            if (tgt_mcmd == RD && tgt_rdy) begin
                tgt_sresp <= DVA;
                tgt_sdata <= mem[tgt_maddr[3:0]];
            end else begin
                tgt_sresp <= NUL;
                tgt_sdata <= '0;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive all three ports at a falling edge, then settle.
    task automatic drive(input logic [2:0] tc, input logic [AW-1:0] ta, input logic [DW-1:0] td,
                         input logic [2:0] hc, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                         input logic [2:0] wc, input logic [AW-1:0] wa);
        @(negedge clk);
        trg_mcmd = tc; trg_maddr = ta; trg_mdata = td;
        hst_mcmd = hc; hst_maddr = ha; hst_mdata = hd;
        wav_mcmd = wc; wav_maddr = wa;
        #1;
    endtask

    task automatic go_idle();
        drive(IDL, '0, '0, IDL, '0, '0, IDL, '0);
    endtask

    localparam logic [DW-1:0] D1 = {32'hA1A1_0001, 32'h1234_5678, 32'hCAFE_0001};
    localparam logic [DW-1:0] D2 = {32'hB2B2_0002, 32'h8765_4321, 32'hBEEF_0002};
    localparam logic [DW-1:0] D3 = {32'hC3C3_0003, 32'h0F0F_F0F0, 32'hD00D_0003};

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1", "trg acc", 128'(trg_scmdaccept), 0);
        chk("R1", "hst acc", 128'(hst_scmdaccept), 0);
        chk("R1", "wav acc", 128'(wav_scmdaccept), 0);
        chk("R1", "resp all", 128'({trg_sresp, hst_sresp, wav_sresp}), 0);
        chk("R2", "tgt cmd idle", 128'(tgt_mcmd), 128'(IDL));
    endtask

    task automatic t_single();
        drive(WR, 12'h005, D1, IDL, '0, '0, IDL, '0);
        chk("R3", "tgt cmd", 128'(tgt_mcmd), 128'(WR));
        chk("R3", "tgt addr", 128'(tgt_maddr), 128'h5);
        chk("R3", "tgt data", 128'(tgt_mdata), 128'(D1));
        chk("R4", "trg acc", 128'(trg_scmdaccept), 1);
        drive(IDL, '0, '0, WR, 12'h006, D2, IDL, '0);
        chk("R7", "host write fwd", 128'({tgt_mcmd, tgt_maddr}), 128'({WR, 12'h006}));
        chk("R7", "host write data", 128'(tgt_mdata), 128'(D2));
        drive(IDL, '0, '0, RD, 12'h005, '0, IDL, '0);
        chk("R7", "host read fwd", 128'({tgt_mcmd, tgt_maddr}), 128'({RD, 12'h005}));
        chk("R4", "hst acc", 128'(hst_scmdaccept), 1);
        go_idle();
        chk("R5", "hst resp", 128'(hst_sresp), 128'(DVA));
        chk("R5", "hst data", 128'(hst_sdata), 128'(D1));
        chk("R5", "others null", 128'({trg_sresp, wav_sresp}), 0);
        chk("R5", "wav data zero", 128'(wav_sdata), 0);
        drive(IDL, '0, '0, IDL, '0, '0, RD, 12'h006);
        chk("R4", "wav acc", 128'(wav_scmdaccept), 1);
        go_idle();
        chk("R5", "wav resp", 128'(wav_sresp), 128'(DVA));
        chk("R5", "wav data", 128'(wav_sdata), 128'(D2));
        chk("R5", "hst null", 128'(hst_sresp), 128'(NUL));
        chk("R2", "idle after", 128'(tgt_mcmd), 128'(IDL));
    endtask

    task automatic t_priority();
        drive(WR, 12'h007, D3, WR, 12'h008, D1, RD, 12'h005);
        chk("R3", "all three: trg wins", 128'({tgt_mcmd, tgt_maddr}), 128'({WR, 12'h007}));
        chk("R3", "all three: data", 128'(tgt_mdata), 128'(D3));
        chk("R4", "acc vector", 128'({trg_scmdaccept, hst_scmdaccept, wav_scmdaccept}), 128'(3'b100));
        drive(IDL, '0, '0, WR, 12'h008, D1, RD, 12'h005);
        chk("R3", "hst over wav", 128'({tgt_mcmd, tgt_maddr}), 128'({WR, 12'h008}));
        chk("R4", "acc vector 2", 128'({trg_scmdaccept, hst_scmdaccept, wav_scmdaccept}), 128'(3'b010));
        drive(IDL, '0, '0, IDL, '0, '0, RD, 12'h007);
        chk("R4", "wav last", 128'(wav_scmdaccept), 1);
        go_idle();
        chk("R5", "wav reads trg data", 128'(wav_sdata), 128'(D3));
    endtask

    task automatic t_illegal();
        drive(RD, 12'h005, '0, IDL, '0, '0, IDL, '0);
        chk("R6", "trg read not fwd", 128'(tgt_mcmd), 128'(IDL));
        chk("R6", "trg read absorbed", 128'(trg_scmdaccept), 1);
        go_idle();
        chk("R6", "trg err", 128'(trg_sresp), 128'(ERR));
        chk("R6", "others null", 128'({hst_sresp, wav_sresp}), 0);
        drive(IDL, '0, '0, RD, 12'h006, '0, WR, 12'h009);
        chk("R6", "host served beside bad wav", 128'({tgt_mcmd, tgt_maddr}), 128'({RD, 12'h006}));
        chk("R6", "both acc", 128'({hst_scmdaccept, wav_scmdaccept}), 128'(2'b11));
        go_idle();
        chk("R6", "wav err", 128'(wav_sresp), 128'(ERR));
        chk("R5", "hst dva beside err", 128'(hst_sresp), 128'(DVA));
        chk("R5", "hst data", 128'(hst_sdata), 128'(D2));
        drive(IDL, '0, '0, 3'b111, 12'h001, '0, IDL, '0);
        chk("R6", "bad code not fwd", 128'(tgt_mcmd), 128'(IDL));
        go_idle();
        chk("R6", "bad code err", 128'(hst_sresp), 128'(ERR));
        chk("R1", "err clears", 128'(trg_sresp), 128'(NUL));
    endtask

    task automatic t_stall();
        tgt_rdy = 1'b0;
        drive(WR, 12'h00A, D1, RD, 12'h005, '0, IDL, '0);
        chk("R8", "trg no acc", 128'(trg_scmdaccept), 0);
        chk("R8", "hst no acc", 128'(hst_scmdaccept), 0);
        drive(IDL, '0, '0, RD, 12'h005, '0, IDL, '0);
        chk("R8", "host read stalled", 128'(hst_scmdaccept), 0);
        go_idle();
        chk("R8", "no answer", 128'(hst_sresp), 128'(NUL));
        tgt_rdy = 1'b1;
    endtask

    task automatic t_starve();
        int wav_hits = 0;
        int hst_hits = 0;
        for (int i = 0; i < 20; i++) begin
            drive(WR, 12'(i), D3, WR, 12'h00F, D2, RD, 12'h006);
            if (wav_scmdaccept) wav_hits++;
            if (hst_scmdaccept) hst_hits++;
        end
        chk("R9", "wav starved", 128'(wav_hits), 0);
        chk("R9", "hst starved", 128'(hst_hits), 0);
        drive(IDL, '0, '0, IDL, '0, '0, RD, 12'h006);
        chk("R9", "wav served in gap", 128'(wav_scmdaccept), 1);
        go_idle();
        chk("R9", "wav answer", 128'(wav_sresp), 128'(DVA));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_priority();
        t_illegal();
        t_stall();
        t_starve();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule